// File: doc/BRIEF.md
# DMA Linked-List Descriptor Sequencer

This block is the per-channel sequencing half of a DMA channel. Software gives it the word address of the first transfer descriptor and sets the channel enable. The block then reads the descriptor from memory as four 32-bit words through a simple read port. It hands the source address, destination address and decoded control fields to a separate transfer engine with a one-cycle start pulse. It then waits for the engine's done pulse. After that it follows the descriptor's link pointer to the next descriptor. No processor work is needed between blocks.

A link pointer whose word-address bits are all zero ends the chain, and the channel clears its own enable. A read error during a descriptor fetch also clears the enable, raises an error pulse and abandons the chain. At the end of each descriptor whose interrupt-enable bit is set, the block raises a terminal-count pulse. Software may clear the enable at any time. The sequencer then goes idle, but it first waits for any read already on the port to complete.

Top module: `dlds_seq`

## Requirements
- R1: After reset, chan_en_o, rd_req_o, xfer_start_o, tc_o and err_o are all low.
- R2: A configuration write with cfg_en_i high, made while the channel is disabled and idle, latches the first descriptor's word address and enables the channel. The descriptor is then read as four words at byte addresses base, base+4, base+8 and base+12, holding in that order the source, the destination, the link pointer and the control word.
- R3: rd_req_o stays high with rd_addr_o unchanged until rd_ack_i is seen, and at most one read is outstanding.
- R4: The cycle after the fourth word is accepted, xfer_start_o pulses high for one cycle. With it, the outputs carry the descriptor fields, decoded from the control word as follows: size in bits 11:0, source burst code in bits 14:12, destination burst code in bits 17:15, source width code in bits 20:18, destination width code in bits 23:21, and interrupt enable in bit 31.
- R5: After xfer_done_i, a nonzero link pointer causes the next descriptor to be fetched at the link address with its two low bits forced to zero.
- R6: A link pointer whose bits 31:2 are zero ends the chain. chan_en_o falls and no further reads are issued.
- R7: tc_o pulses for exactly one cycle, in the cycle after xfer_done_i, for each descriptor whose interrupt-enable bit is set, and at no other time.
- R8: A read acknowledged with rd_err_i high produces a one-cycle err_o pulse and clears chan_en_o. It starts no transfer and issues no further reads.
- R9: A configuration write with cfg_en_i low clears chan_en_o on the next edge. A read already outstanding stays requested until acknowledged, and its data is then discarded. No new read or transfer start follows, and a done arriving afterwards raises no tc_o.
- R10: A configuration write with cfg_en_i high while the channel is enabled or still busy is ignored. The running chain is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value written with the strobe |
| cfg_head_word_i | input | 30 | Bits 31:2 of the first descriptor address |
| chan_en_o | output | 1 | Channel enable state |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_ack_i | input | 1 | Read completes this cycle |
| rd_err_i | input | 1 | Completing read failed |
| rd_data_i | input | 32 | Read data, valid with rd_ack_i |
| xfer_start_o | output | 1 | One-cycle start to the transfer engine |
| xfer_src_o | output | 32 | Source start address |
| xfer_dst_o | output | 32 | Destination address |
| xfer_size_o | output | 12 | Transfer size |
| xfer_sburst_o | output | 3 | Source burst code |
| xfer_dburst_o | output | 3 | Destination burst code |
| xfer_swidth_o | output | 3 | Source width code |
| xfer_dwidth_o | output | 3 | Destination width code |
| xfer_done_i | input | 1 | Transfer engine finished the descriptor |
| tc_o | output | 1 | Terminal-count pulse |
| err_o | output | 1 | Fetch error pulse |

## Verification
If the state register took a wrong step, the port would show it at the very next read. An address out of the base/+4/+8/+12 order, or a read issued after the chain should have ended, fails the read-address scoreboard when that read is acknowledged. A wrong word slot or stale descriptor field shows at the following xfer_start_o, where the monitor compares every field. A mishandled enable or error path shows within a few cycles as chan_en_o staying high, an extra start, or a wrong count of tc_o and err_o pulses.

// File: rtl/dlds_pkg.sv
package dlds_pkg;

    localparam int WORD_W     = 32;
    localparam int PTR_W      = WORD_W - 2;
    localparam int SIZE_W     = 12;
    localparam int BURST_W    = 3;
    localparam int WID_W      = 3;
    localparam int SIZE_LSB   = 0;
    localparam int SBURST_LSB = SIZE_LSB + SIZE_W;
    localparam int DBURST_LSB = SBURST_LSB + BURST_W;
    localparam int SWID_LSB   = DBURST_LSB + BURST_W;
    localparam int DWID_LSB   = SWID_LSB + WID_W;
    localparam int IE_BIT     = WORD_W - 1;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_XFER,
        ST_NEXT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [SIZE_W-1:0]  size;
        logic [BURST_W-1:0] sburst;
        logic [BURST_W-1:0] dburst;
        logic [WID_W-1:0]   swid;
        logic [WID_W-1:0]   dwid;
        logic               irq_en;
    } ctrl_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [PTR_W-1:0]  link_w;
        ctrl_t             ctrl;
    } desc_t;

    function automatic logic is_fetch(input seq_state_e s);
        return (s == ST_FETCH0) || (s == ST_FETCH1) ||
               (s == ST_FETCH2) || (s == ST_FETCH3);
    endfunction

    function automatic seq_state_e next_fetch(input seq_state_e s);
        case (s)
            ST_FETCH0: return ST_FETCH1;
            ST_FETCH1: return ST_FETCH2;
            ST_FETCH2: return ST_FETCH3;
            default:   return ST_XFER;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] word_index(input seq_state_e s);
        case (s)
            ST_FETCH1: return IDX_W'(1);
            ST_FETCH2: return IDX_W'(2);
            ST_FETCH3: return IDX_W'(3);
            default:   return IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/dlds_desc_store.sv
module dlds_desc_store
    import dlds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output desc_t             desc
);

    logic [WORD_W-1:0] addr_q [2];
    logic [PTR_W-1:0]  link_q;
    ctrl_t             ctrl_q;

    // Address words: one register per slot
    for (genvar g = 0; g < 2; g++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                addr_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= '0;
        end else if (we && idx == IDX_W'(2)) begin
            link_q <= wdata[WORD_W-1:2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we && idx == IDX_W'(3)) begin
            ctrl_q.size   <= wdata[SIZE_LSB   +: SIZE_W];
            ctrl_q.sburst <= wdata[SBURST_LSB +: BURST_W];
            ctrl_q.dburst <= wdata[DBURST_LSB +: BURST_W];
            ctrl_q.swid   <= wdata[SWID_LSB   +: WID_W];
            ctrl_q.dwid   <= wdata[DWID_LSB   +: WID_W];
            ctrl_q.irq_en <= wdata[IE_BIT];
        end
    end

    always_comb begin
        desc.src    = addr_q[0];
        desc.dst    = addr_q[1];
        desc.link_w = link_q;
        desc.ctrl   = ctrl_q;
    end

endmodule

// File: rtl/dlds_evt.sv
module dlds_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire,
    output logic [N-1:0] pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= '0;
        end else begin
            pulse <= fire;
        end
    end

endmodule

// File: rtl/dlds_ctl.sv
module dlds_ctl
    import dlds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [PTR_W-1:0]  cfg_head_w,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic              xfer_done,
    input  logic [PTR_W-1:0]  link_w,
    input  logic              irq_en,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    output logic              cap_we,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              launch,
    output logic              tc_hit,
    output logic              err_hit,
    output logic              chan_en
);

    seq_state_e       st_q, st_d;
    logic             en_q;
    logic             en_clr;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             sw_off;
    logic             stay;
    logic             arm;

    assign sw_off  = cfg_wr && !cfg_en;
    assign stay    = en_q && !sw_off;
    assign arm     = cfg_wr && cfg_en && !en_q && (st_q == ST_IDLE);
    assign rd_req  = is_fetch(st_q);
    assign cap_idx = word_index(st_q);
    assign rd_addr = {ptr_q + {{(PTR_W-IDX_W){1'b0}}, cap_idx}, 2'b00};
    assign chan_en = en_q;

    always_comb begin
        st_d    = st_q;
        ptr_d   = ptr_q;
        launch  = 1'b0;
        tc_hit  = 1'b0;
        err_hit = 1'b0;
        cap_we  = 1'b0;
        en_clr  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (stay) begin
                    st_d  = ST_FETCH0;
                    ptr_d = head_q;
                end
            end
            ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_FETCH3: begin
                if (rd_ack) begin
                    if (!stay) begin
                        st_d = ST_IDLE;
                    end else if (rd_err) begin
                        st_d    = ST_IDLE;
                        err_hit = 1'b1;
                        en_clr  = 1'b1;
                    end else begin
                        cap_we = 1'b1;
                        st_d   = next_fetch(st_q);
                        launch = (st_q == ST_FETCH3);
                    end
                end
            end
            ST_XFER: begin
                if (!stay) begin
                    st_d = ST_IDLE;
                end else if (xfer_done) begin
                    st_d   = ST_NEXT;
                    tc_hit = irq_en;
                end
            end
            ST_NEXT: begin
                if (!stay) begin
                    st_d = ST_IDLE;
                end else if (link_w == '0) begin
                    st_d = ST_DONE;
                end else begin
                    st_d  = ST_FETCH0;
                    ptr_d = link_w;
                end
            end
            ST_DONE: begin
                st_d   = ST_IDLE;
                en_clr = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            head_q <= '0;
        end else if (sw_off || en_clr) begin
            en_q <= 1'b0;
        end else if (arm) begin
            en_q   <= 1'b1;
            head_q <= cfg_head_w;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R3

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && !rd_err && stay && cap_idx != IDX_W'(3))
        |=> (rd_req && rd_addr == $past(rd_addr) + WORD_W'(4))); // R2

    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (rst)
        err_hit |=> (!chan_en && !rd_req)); // R8

    AST_END_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE) |=> (!chan_en && !rd_req)); // R6

    AST_OFF_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (sw_off && !rd_req) |=> !rd_req); // R9

    AST_BUSY_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_en && (en_q || st_q != ST_IDLE)) |=> $stable(head_q)); // R10

endmodule

// File: rtl/dlds_seq.sv
module dlds_seq
    import dlds_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_i,
    input  logic               cfg_en_i,
    input  logic [PTR_W-1:0]   cfg_head_word_i,
    output logic               chan_en_o,
    output logic               rd_req_o,
    output logic [WORD_W-1:0]  rd_addr_o,
    input  logic               rd_ack_i,
    input  logic               rd_err_i,
    input  logic [WORD_W-1:0]  rd_data_i,
    output logic               xfer_start_o,
    output logic [WORD_W-1:0]  xfer_src_o,
    output logic [WORD_W-1:0]  xfer_dst_o,
    output logic [SIZE_W-1:0]  xfer_size_o,
    output logic [BURST_W-1:0] xfer_sburst_o,
    output logic [BURST_W-1:0] xfer_dburst_o,
    output logic [WID_W-1:0]   xfer_swidth_o,
    output logic [WID_W-1:0]   xfer_dwidth_o,
    input  logic               xfer_done_i,
    output logic               tc_o,
    output logic               err_o
);

    localparam int EVT_N = 3;

    desc_t            desc;
    logic             cap_we;
    logic [IDX_W-1:0] cap_idx;
    logic             launch, tc_hit, err_hit;
    logic [EVT_N-1:0] evt_q;

    dlds_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr_i),
        .cfg_en     (cfg_en_i),
        .cfg_head_w (cfg_head_word_i),
        .rd_ack     (rd_ack_i),
        .rd_err     (rd_err_i),
        .xfer_done  (xfer_done_i),
        .link_w     (desc.link_w),
        .irq_en     (desc.ctrl.irq_en),
        .rd_req     (rd_req_o),
        .rd_addr    (rd_addr_o),
        .cap_we     (cap_we),
        .cap_idx    (cap_idx),
        .launch     (launch),
        .tc_hit     (tc_hit),
        .err_hit    (err_hit),
        .chan_en    (chan_en_o)
    );

    dlds_desc_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cap_we),
        .idx   (cap_idx),
        .wdata (rd_data_i),
        .desc  (desc)
    );

    dlds_evt #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .fire  ({launch, tc_hit, err_hit}),
        .pulse (evt_q)
    );

    assign xfer_start_o  = evt_q[2];
    assign tc_o          = evt_q[1];
    assign err_o         = evt_q[0];
    assign xfer_src_o    = desc.src;
    assign xfer_dst_o    = desc.dst;
    assign xfer_size_o   = desc.ctrl.size;
    assign xfer_sburst_o = desc.ctrl.sburst;
    assign xfer_dburst_o = desc.ctrl.dburst;
    assign xfer_swidth_o = desc.ctrl.swid;
    assign xfer_dwidth_o = desc.ctrl.dwid;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start_o |=> !xfer_start_o); // R4

    AST_TC_PULSE: assert property (@(posedge clk) disable iff (rst)
        tc_o |=> !tc_o); // R7

    AST_TC_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> $past(xfer_done_i)); // R7

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !xfer_start_o); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!xfer_start_o && !tc_o && !err_o && !chan_en_o)); // R1

endmodule

// File: tb/dlds_seq_test.sv
module dlds_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic [29:0] cfg_head = '0;
    logic        chan_en_o, rd_req_o, xfer_start_o, tc_o, err_o;
    logic [31:0] rd_addr_o, xfer_src_o, xfer_dst_o;
    logic        rd_ack_i = 1'b0;
    logic        rd_err_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [11:0] xfer_size_o;
    logic [2:0]  xfer_sburst_o, xfer_dburst_o, xfer_swidth_o, xfer_dwidth_o;
    logic        xfer_done_i = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int lat = 1;
    int lat_cnt = 0;
    int eng_delay = 3;
    int eng_cnt = 0;
    bit eng_busy = 1'b0;
    int reads = 0;
    int starts = 0;
    int tcs = 0;
    int errs = 0;
    bit finished = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    logic [31:0] mem [256];
    logic [31:0] exp_addr [$];
    logic [95:0] exp_desc [$];

    always #10 clk = ~clk;

    dlds_seq uut (
        .clk(clk), .rst(rst),
        .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en), .cfg_head_word_i(cfg_head),
        .chan_en_o(chan_en_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i), .rd_data_i(rd_data_i),
        .xfer_start_o(xfer_start_o), .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o),
        .xfer_size_o(xfer_size_o), .xfer_sburst_o(xfer_sburst_o),
        .xfer_dburst_o(xfer_dburst_o), .xfer_swidth_o(xfer_swidth_o),
        .xfer_dwidth_o(xfer_dwidth_o), .xfer_done_i(xfer_done_i),
        .tc_o(tc_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctrl(input logic [11:0] size, input logic [2:0] sb,
                                           input logic [2:0] db, input logic [2:0] sw,
                                           input logic [2:0] dw, input logic ie);
        return {ie, 7'b0, dw, sw, db, sb, size};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] lk, input logic [31:0] c);
        mem[a[9:2]]      = s;
        mem[a[9:2] + 1]  = d;
        mem[a[9:2] + 2]  = lk;
        mem[a[9:2] + 3]  = c;
    endtask

    // Driver side of the scoreboard: four reads in order, then one start
    task automatic expect_desc(input logic [31:0] a);
        for (int k = 0; k < 4; k++) exp_addr.push_back(a + 32'(4 * k));
        exp_desc.push_back({mem[a[9:2]], mem[a[9:2] + 1], mem[a[9:2] + 3]});
    endtask

    task automatic cfg_write(input logic en, input logic [31:0] a);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_en   = en;
        cfg_head = a[31:2];
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!chan_en_o && !rd_req_o && !eng_busy && !rd_ack_i) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_start(input int base);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (starts > base) break;
        end
    endtask

    // Memory responder and read-address scoreboard
    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i <= 1'b0;
            rd_err_i <= 1'b0;
        end else if (rd_req_o) begin
            if (lat_cnt >= lat) begin
                lat_cnt   <= 0;
                rd_ack_i  <= 1'b1;
                rd_data_i <= mem[rd_addr_o[9:2]];
                rd_err_i  <= (rd_addr_o == err_addr);
                reads++;
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R6 unexpected read", 96'(rd_addr_o), 96'(0));
                end else begin
                    logic [31:0] ea;
                    ea = exp_addr.pop_front();
                    check(rd_addr_o == ea, "R2/R5 read address", 96'(rd_addr_o), 96'(ea));
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Transfer engine model and descriptor monitor
    always @(negedge clk) begin
        xfer_done_i <= 1'b0;
        if (xfer_start_o) begin
            starts++;
            if (exp_desc.size() == 0) begin
                check(1'b0, "R4 unexpected start", 96'(xfer_src_o), 96'(0));
            end else begin
                logic [95:0] e;
                logic [31:0] c;
                logic [95:0] got;
                logic [95:0] want;
                e    = exp_desc.pop_front();
                c    = e[31:0];
                got  = {xfer_src_o, xfer_dst_o, 8'b0, xfer_dwidth_o, xfer_swidth_o,
                        xfer_dburst_o, xfer_sburst_o, xfer_size_o};
                want = {e[95:64], e[63:32], 8'b0, c[23:21], c[20:18], c[17:15],
                        c[14:12], c[11:0]};
                check(got == want, "R4 descriptor fields", got, want);
            end
            eng_cnt  <= eng_delay;
            eng_busy <= 1'b1;
        end else if (eng_busy) begin
            if (eng_cnt == 0) begin
                xfer_done_i <= 1'b1;
                eng_busy    <= 1'b0;
            end else begin
                eng_cnt <= eng_cnt - 1;
            end
        end
        if (tc_o)  tcs++;
        if (err_o) errs++;
    end

    // Watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0, t0, e0, r0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        put_desc(32'h100, 32'h0000_A200, 32'h8000_0040, 32'h110,
                 mkctrl(12'hC00, 3'd4, 3'd4, 3'd2, 3'd2, 1'b1));
        put_desc(32'h110, 32'h0000_B200, 32'h8000_0044, 32'h123,
                 mkctrl(12'h300, 3'd3, 3'd2, 3'd1, 3'd2, 1'b0));
        put_desc(32'h120, 32'h0001_1200, 32'h8000_0048, 32'h0,
                 mkctrl(12'h010, 3'd0, 3'd1, 3'd0, 3'd0, 1'b1));
        put_desc(32'h140, 32'h0000_1234, 32'h0000_5678, 32'h3,
                 mkctrl(12'hFFF, 3'd7, 3'd7, 3'd7, 3'd7, 1'b1));
        put_desc(32'h180, 32'h0000_0AAA, 32'h0000_0BBB, 32'h100,
                 mkctrl(12'h001, 3'd1, 3'd1, 3'd1, 3'd1, 1'b1));

        repeat (3) @(negedge clk);
        // R1: reset state
        check(chan_en_o == 0, "R1 chan_en", 96'(chan_en_o), 96'(0));
        check(rd_req_o == 0, "R1 rd_req", 96'(rd_req_o), 96'(0));
        check(xfer_start_o == 0, "R1 start", 96'(xfer_start_o), 96'(0));
        check(tc_o == 0 && err_o == 0, "R1 events", 96'({tc_o, err_o}), 96'(0));
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(chan_en_o == 0 && rd_req_o == 0, "R1 idle after reset",
              96'({chan_en_o, rd_req_o}), 96'(0));

        // Three-descriptor chain, masked link, end on zero link (R2 R4 R5 R6 R7)
        lat = 1; eng_delay = 3;
        expect_desc(32'h100); expect_desc(32'h110); expect_desc(32'h120);
        s0 = starts; t0 = tcs;
        cfg_write(1'b1, 32'h100);
        check(chan_en_o == 1, "R2 enable latched", 96'(chan_en_o), 96'(1));
        wait_quiet();
        check(starts - s0 == 3, "R4 start count", 96'(starts - s0), 96'(3));
        check(tcs - t0 == 2, "R7 tc count", 96'(tcs - t0), 96'(2));
        check(exp_addr.size() == 0, "R5 all reads made", 96'(exp_addr.size()), 96'(0));
        check(chan_en_o == 0, "R6 enable cleared at end", 96'(chan_en_o), 96'(1'b0));
        r0 = reads;
        repeat (20) @(negedge clk);
        check(reads == r0, "R6 no reads after end", 96'(reads), 96'(r0));

        // Error on the link word fetch (R8)
        lat = 0; err_addr = 32'h188;
        exp_addr.push_back(32'h180); exp_addr.push_back(32'h184); exp_addr.push_back(32'h188);
        s0 = starts; e0 = errs;
        cfg_write(1'b1, 32'h180);
        wait_quiet();
        check(errs - e0 == 1, "R8 err pulse", 96'(errs - e0), 96'(1));
        check(starts == s0, "R8 no start", 96'(starts), 96'(s0));
        check(chan_en_o == 0, "R8 enable cleared", 96'(chan_en_o), 96'(0));
        check(exp_addr.size() == 0, "R8 reads up to error", 96'(exp_addr.size()), 96'(0));
        err_addr = 32'hFFFF_FFFF;

        // Software disable with a read outstanding (R9)
        lat = 6;
        exp_addr.push_back(32'h100);
        s0 = starts;
        cfg_write(1'b1, 32'h100);
        @(negedge clk);
        cfg_write(1'b0, 32'h0);
        check(chan_en_o == 0, "R9 enable off", 96'(chan_en_o), 96'(0));
        check(rd_req_o == 1, "R9 read held until ack", 96'(rd_req_o), 96'(1));
        wait_quiet();
        check(starts == s0, "R9 no start after disable", 96'(starts), 96'(s0));
        check(exp_addr.size() == 0, "R9 outstanding read done", 96'(exp_addr.size()), 96'(0));

        // Re-enable while busy is ignored; link 0x3 ends chain (R10 R6)
        lat = 0; eng_delay = 20;
        expect_desc(32'h140);
        s0 = starts; t0 = tcs;
        cfg_write(1'b1, 32'h140);
        wait_start(s0);
        cfg_write(1'b1, 32'h180);
        check(chan_en_o == 1, "R10 channel still running", 96'(chan_en_o), 96'(1));
        wait_quiet();
        check(starts - s0 == 1, "R10 one start only", 96'(starts - s0), 96'(1));
        check(tcs - t0 == 1, "R7 tc for single descriptor", 96'(tcs - t0), 96'(1));
        check(chan_en_o == 0, "R6 low-bit link ends chain", 96'(chan_en_o), 96'(0));

        // Disable during transfer: later done gives no tc (R9)
        eng_delay = 10;
        expect_desc(32'h100);
        s0 = starts; t0 = tcs;
        cfg_write(1'b1, 32'h100);
        wait_start(s0);
        cfg_write(1'b0, 32'h0);
        wait_quiet();
        check(tcs == t0, "R9 no tc after disable", 96'(tcs), 96'(t0));
        check(starts - s0 == 1, "R9 single start", 96'(starts - s0), 96'(1));

        // Full chain again with zero latency (R2 R3 R5 R7)
        lat = 0; eng_delay = 0;
        expect_desc(32'h100); expect_desc(32'h110); expect_desc(32'h120);
        s0 = starts; t0 = tcs;
        cfg_write(1'b1, 32'h100);
        wait_quiet();
        check(starts - s0 == 3, "R3 chain at zero latency", 96'(starts - s0), 96'(3));
        check(tcs - t0 == 2, "R7 tc count rerun", 96'(tcs - t0), 96'(2));
        check(exp_desc.size() == 0, "R4 all descriptors seen", 96'(exp_desc.size()), 96'(0));

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule